// File: doc/BRIEF.md
# Trace Buffer Write Controller

This block takes a stream of trace bytes and stores them one at a time into a circular region of memory. The region starts at a base pointer, which is aligned to 4 KB, and ends just below a limit address, which is also aligned to 4 KB. A write pointer steps through the region one byte at a time. When the pointer reaches the limit it reloads the base pointer; this is called a wrap. A single control register holds the limit, an enable bit, an address-mode flag, and two 2-bit mode fields. One mode field sets what a wrap does. The other sets what an external trigger does. For each of the two events, the mode decides on its own whether collection stops and whether the maintenance interrupt is raised.

Every accepted byte first goes into a one-entry staging register. That register drives a simple byte-wide memory write port in the following cycle. A trigger that requests a stop first lets the staging register drain. Only after that does the block stop and raise the interrupt. The interrupt is sticky until it is cleared. A stopped unit stays stopped until software clears the enable bit and then sets it again.

Top module: `trace_buf_wctl`

## Requirements
- R1: After reset, mem_we_o, irq_o and stopped_o are 0 and ctl_rdata_o reads all zeros.
- R2: ctl_rdata_o returns the control register in this layout:
  - bit 0: enable
  - bits [2:1]: fill mode
  - bits [4:3]: trigger mode
  - bit 5: address-mode flag
  - bits [11:6]: always read 0
  - bits [AW-1:12]: limit, as written
  The limit address is that field with 12 zero bits appended below it.
- R3: A byte (data_valid_i high at a clock edge) is accepted only while the unit is enabled and running. While the enable bit is 0, incoming bytes are discarded and mem_we_o stays low. After the enable bit changes from 0 to 1, the unit runs from the second rising edge after the write.
- R4: A byte accepted at an edge appears in the next cycle as mem_we_o=1, mem_addr_o equal to the write pointer at the time of acceptance, and mem_wdata_o equal to the byte. The pointer then advances by one.
- R5: A byte accepted at address limit-1 is a wrap: the pointer reloads the base pointer. A write with base_we_i loads the base pointer (bits [11:0] forced to 0) and also reloads the write pointer; this load takes priority over a pointer advance in the same cycle.
- R6: Fill mode 2'b00: a wrap stops collection (stopped_o=1 from the next cycle) and sets irq_o.
- R7: Fill mode 2'b01: a wrap sets irq_o and collection continues.
- R8: Fill modes 2'b11 and 2'b10: a wrap neither sets irq_o nor stops collection.
- R9: Trigger mode 2'b00: when trig_i is high while the unit is running, no further byte is accepted. Any staged byte is still written. Then stopped_o and irq_o are set together.
- R10: Trigger mode 2'b01: a trigger sets irq_o and collection continues. Trigger modes 2'b11 and 2'b10 ignore the trigger.
- R11: irq_o stays set until irq_clr_i is high at an edge. If a new interrupt event happens at the same edge, the set wins.
- R12: Once stopped, stopped_o stays 1 and no bytes are accepted until the enable bit is written 0 and then 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | AW | Control register write data |
| ctl_rdata_o | output | AW | Control register readback |
| base_we_i | input | 1 | Base pointer write strobe |
| base_i | input | AW | Base pointer value (low 12 bits ignored) |
| irq_clr_i | input | 1 | Clears the maintenance interrupt |
| trig_i | input | 1 | Trigger event |
| data_valid_i | input | 1 | Trace byte valid |
| data_i | input | DW | Trace byte |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory write address |
| mem_wdata_o | output | DW | Memory write data |
| irq_o | output | 1 | Maintenance interrupt, sticky |
| stopped_o | output | 1 | Collection stopped |

## Verification
The properties assume the limit address is above the base pointer. They also assume the limit, the mode fields and the base are changed only while the unit is disabled, or in the case of the base, while the bench reloads the pointer on purpose. The stimulus therefore sets up every run with the enable bit at 0, using a single 4 KB region. Random bytes are driven at a chosen density, and each trigger is a single pulse placed in a chosen cycle. A bench-side model, built from the requirements, predicts the memory port, the interrupt and the stop flag for every cycle.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  localparam int unsigned PG_BITS = 12;

  typedef enum logic [1:0] {
    FILL_STOP = 2'b00,
    FILL_IRQ  = 2'b01,
    FILL_RSV  = 2'b10,
    FILL_CIRC = 2'b11
  } fill_mode_e;

  typedef enum logic [1:0] {
    TRG_STOP = 2'b00,
    TRG_IRQ  = 2'b01,
    TRG_RSV  = 2'b10,
    TRG_IGN  = 2'b11
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_RUN   = 2'b01,
    ST_FLUSH = 2'b10,
    ST_HALT  = 2'b11
  } run_state_e;

  typedef struct packed {
    logic stop;
    logic irq;
  } evt_act_t;

  // reserved encodings fall back to the no-action setting
  function automatic evt_act_t fill_action(fill_mode_e m);
    evt_act_t a;
    unique case (m)
      FILL_STOP: a = '{stop: 1'b1, irq: 1'b1};
      FILL_IRQ:  a = '{stop: 1'b0, irq: 1'b1};
      default:   a = '{stop: 1'b0, irq: 1'b0};
    endcase
    return a;
  endfunction

  function automatic evt_act_t trig_action(trig_mode_e m);
    evt_act_t a;
    unique case (m)
      TRG_STOP: a = '{stop: 1'b1, irq: 1'b1};
      TRG_IRQ:  a = '{stop: 1'b0, irq: 1'b1};
      default:  a = '{stop: 1'b0, irq: 1'b0};
    endcase
    return a;
  endfunction
endpackage

// File: rtl/tbw_ctl_regs.sv
module tbw_ctl_regs
  import tbw_pkg::*;
#(
  parameter int unsigned AW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic [AW-1:0] ctl_wdata_i,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  output logic          en_o,
  output fill_mode_e    fm_o,
  output trig_mode_e    tm_o,
  output logic [AW-1:0] limit_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] rdata_o
);
  localparam int unsigned HW = AW - PG_BITS;

  logic          en_q, am_q;
  fill_mode_e    fm_q;
  trig_mode_e    tm_q;
  logic [HW-1:0] lim_q, base_q;
  logic          unused_bits;

  assign unused_bits = ^{base_i[PG_BITS-1:0], ctl_wdata_i[PG_BITS-1:6]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      am_q  <= 1'b0;
      fm_q  <= FILL_STOP;
      tm_q  <= TRG_STOP;
      lim_q <= '0;
    end else if (ctl_we_i) begin
      en_q  <= ctl_wdata_i[0];
      fm_q  <= fill_mode_e'(ctl_wdata_i[2:1]);
      tm_q  <= trig_mode_e'(ctl_wdata_i[4:3]);
      am_q  <= ctl_wdata_i[5];
      lim_q <= ctl_wdata_i[AW-1:PG_BITS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= '0;
    else if (base_we_i) base_q <= base_i[AW-1:PG_BITS];
  end

  assign en_o    = en_q;
  assign fm_o    = fm_q;
  assign tm_o    = tm_q;
  assign limit_o = {lim_q, {PG_BITS{1'b0}}};
  assign base_o  = {base_q, {PG_BITS{1'b0}}};
  assign rdata_o = {lim_q, 6'b0, am_q, tm_q, fm_q, en_q};
endmodule

// File: rtl/tbw_wptr.sv
module tbw_wptr #(
  parameter int unsigned AW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] wptr_o,
  output logic          wrap_o
);
  logic [AW-1:0] wptr_q, wptr_inc;

  assign wptr_inc = wptr_q + AW'(1);
  assign wrap_o   = adv_i && (wptr_inc == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wptr_q <= '0;
    else if (load_i) wptr_q <= load_val_i;
    else if (adv_i)  wptr_q <= wrap_o ? base_i : wptr_inc;
  end

  assign wptr_o = wptr_q;
endmodule

// File: rtl/tbw_stage.sv
module tbw_stage #(
  parameter int unsigned AW = 64,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          vld_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= load_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
    end else if (load_i) begin
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/tbw_seq.sv
module tbw_seq
  import tbw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  fill_mode_e fm_i,
  input  trig_mode_e tm_i,
  input  logic       trig_i,
  input  logic       wrap_i,
  input  logic       stage_vld_i,
  input  logic       irq_clr_i,
  output logic       accept_o,
  output logic       trig_hit_o,
  output logic       irq_o,
  output logic       stopped_o
);
  run_state_e st_q, st_d;
  evt_act_t   f_act, t_act;
  logic       irq_q, irq_set, drained;

  assign f_act      = fill_action(fm_i);
  assign t_act      = trig_action(tm_i);
  assign accept_o   = (st_q == ST_RUN) && en_i;
  assign trig_hit_o = accept_o && trig_i;
  assign drained    = (st_q == ST_FLUSH) && en_i && !stage_vld_i;

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_RUN;
        ST_RUN: begin
          if (trig_hit_o && t_act.stop)  st_d = ST_FLUSH;
          else if (wrap_i && f_act.stop) st_d = ST_HALT;
        end
        ST_FLUSH: if (!stage_vld_i) st_d = ST_HALT;
        default:  st_d = ST_HALT;
      endcase
    end
  end

  // stop-on-trigger raises its interrupt when the flush completes
  assign irq_set = (wrap_i && f_act.irq)
                 || (trig_hit_o && t_act.irq && !t_act.stop)
                 || drained;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      irq_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign irq_o     = irq_q;
  assign stopped_o = (st_q == ST_HALT);
endmodule

// File: rtl/trace_buf_wctl.sv
module trace_buf_wctl
  import tbw_pkg::*;
#(
  parameter int unsigned AW = 64,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic [AW-1:0] ctl_wdata_i,
  output logic [AW-1:0] ctl_rdata_o,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  input  logic          irq_clr_i,
  input  logic          trig_i,
  input  logic          data_valid_i,
  input  logic [DW-1:0] data_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          irq_o,
  output logic          stopped_o
);
  logic          en_q, accept, take, wrap_hit, trig_hit;
  fill_mode_e    fm;
  trig_mode_e    tm;
  logic [AW-1:0] limit_addr, base_addr, wptr, base_load;

  assign base_load = {base_i[AW-1:PG_BITS], {PG_BITS{1'b0}}};
  assign take      = accept && data_valid_i;

  tbw_ctl_regs #(.AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .base_we_i   (base_we_i),
    .base_i      (base_i),
    .en_o        (en_q),
    .fm_o        (fm),
    .tm_o        (tm),
    .limit_o     (limit_addr),
    .base_o      (base_addr),
    .rdata_o     (ctl_rdata_o)
  );

  tbw_wptr #(.AW(AW)) u_wptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (base_we_i),
    .adv_i      (take),
    .base_i     (base_addr),
    .limit_i    (limit_addr),
    .load_val_i (base_load),
    .wptr_o     (wptr),
    .wrap_o     (wrap_hit)
  );

  tbw_stage #(.AW(AW), .DW(DW)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take),
    .addr_i (wptr),
    .data_i (data_i),
    .vld_o  (mem_we_o),
    .addr_o (mem_addr_o),
    .data_o (mem_wdata_o)
  );

  tbw_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .fm_i        (fm),
    .tm_i        (tm),
    .trig_i      (trig_i),
    .wrap_i      (wrap_hit),
    .stage_vld_i (mem_we_o),
    .irq_clr_i   (irq_clr_i),
    .accept_o    (accept),
    .trig_hit_o  (trig_hit),
    .irq_o       (irq_o),
    .stopped_o   (stopped_o)
  );
endmodule

// File: rtl/tbw_chk.sv
module tbw_chk #(
  parameter int unsigned AW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_q,
  input logic [1:0]    fm,
  input logic          take,
  input logic          wrap_hit,
  input logic          trig_hit,
  input logic          mem_we_o,
  input logic          irq_o,
  input logic          irq_clr_i,
  input logic          stopped_o,
  input logic [AW-1:0] ctl_rdata_o
);
  // R3
  off_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !mem_we_o);

  // R6
  fill_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && wrap_hit && fm == 2'b00 |=> irq_o);

  // R7
  fill_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && wrap_hit && fm == 2'b01 |=> irq_o && !stopped_o);

  // R8
  fill_circ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && wrap_hit && fm[1] && !trig_hit && !irq_o |=> !irq_o && !stopped_o);

  // R11
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);

  // R12
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o && ctl_rdata_o[0] |=> stopped_o);

  // R9
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o && $past(stopped_o) |-> !mem_we_o);
endmodule

bind trace_buf_wctl tbw_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_q        (en_q),
  .fm          (fm),
  .take        (take),
  .wrap_hit    (wrap_hit),
  .trig_hit    (trig_hit),
  .mem_we_o    (mem_we_o),
  .irq_o       (irq_o),
  .irq_clr_i   (irq_clr_i),
  .stopped_o   (stopped_o),
  .ctl_rdata_o (ctl_rdata_o)
);

// File: tb/sim_trace_buf_wctl.sv
module sim_trace_buf_wctl;
  localparam logic [63:0] BASE  = 64'h0000_0000_8000_3000;
  localparam logic [63:0] LIMIT = 64'h0000_0000_8000_4000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_we_i = 1'b0, base_we_i = 1'b0, irq_clr_i = 1'b0;
  logic        trig_i = 1'b0, data_valid_i = 1'b0;
  logic [63:0] ctl_wdata_i = '0, base_i = '0;
  logic [7:0]  data_i = '0;
  logic [63:0] ctl_rdata_o, mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_we_o, irq_o, stopped_o;

  int vecs = 0;
  int fails = 0;
  string cur_req = "R4";

  // reference state
  logic        m_en, m_am, m_irq, m_sv;
  logic [1:0]  m_fm, m_tm, m_st;
  logic [63:0] m_lim, m_base, m_wptr, m_sa;
  logic [7:0]  m_sd;

  always #2.5 clk_i = ~clk_i;

  trace_buf_wctl u0 (.*);

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  function automatic logic f_stop(logic [1:0] m); return m == 2'b00; endfunction
  function automatic logic f_irq(logic [1:0] m);  return m == 2'b00 || m == 2'b01; endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_am = 0; m_irq = 0; m_sv = 0; m_fm = 0; m_tm = 0; m_st = 0;
    m_lim = 0; m_base = 0; m_wptr = 0; m_sa = 0; m_sd = 0;
  endtask

  task automatic model_step();
    logic acc, tk, th, wr, iset;
    logic [1:0] nst;
    acc = (m_st == 2'd1) && m_en;
    tk  = acc && data_valid_i;
    th  = acc && trig_i;
    wr  = tk && (m_wptr + 64'd1 == m_lim);
    iset = (wr && f_irq(m_fm)) || (th && f_irq(m_tm) && !f_stop(m_tm))
         || (m_st == 2'd2 && m_en && !m_sv);
    nst = m_st;
    if (!m_en) nst = 2'd0;
    else case (m_st)
      2'd0: nst = 2'd1;
      2'd1: if (th && f_stop(m_tm)) nst = 2'd2; else if (wr && f_stop(m_fm)) nst = 2'd3;
      2'd2: if (!m_sv) nst = 2'd3;
      default: nst = 2'd3;
    endcase
    if (iset) m_irq = 1; else if (irq_clr_i) m_irq = 0;
    m_sv = tk;
    if (tk) begin m_sa = m_wptr; m_sd = data_i; end
    if (base_we_i) m_wptr = {base_i[63:12], 12'h0};
    else if (tk) m_wptr = wr ? m_base : m_wptr + 64'd1;
    m_st = nst;
    if (ctl_we_i) begin
      m_en = ctl_wdata_i[0]; m_fm = ctl_wdata_i[2:1]; m_tm = ctl_wdata_i[4:3];
      m_am = ctl_wdata_i[5]; m_lim = {ctl_wdata_i[63:12], 12'h0};
    end
    if (base_we_i) m_base = {base_i[63:12], 12'h0};
  endtask

  task automatic compare();
    chk("R4 mem_we", {63'd0, mem_we_o}, {63'd0, m_sv});
    if (m_sv) begin
      chk("R4 mem_addr", mem_addr_o, m_sa);
      chk("R4 mem_wdata", {56'd0, mem_wdata_o}, {56'd0, m_sd});
    end
    chk({cur_req, " irq"}, {63'd0, irq_o}, {63'd0, m_irq});
    chk({cur_req, " stopped"}, {63'd0, stopped_o}, {63'd0, m_st == 2'd3});
    chk("R2 readback", ctl_rdata_o, {m_lim[63:12], 6'b0, m_am, m_tm, m_fm, m_en});
  endtask

  task automatic step();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare();
    ctl_we_i = 0; base_we_i = 0; irq_clr_i = 0; trig_i = 0;
  endtask

  task automatic wr_ctl(logic [63:0] v);
    ctl_wdata_i = v; ctl_we_i = 1; step();
  endtask

  task automatic setup(logic [1:0] fm, logic [1:0] tm);
    wr_ctl(LIMIT | {59'd0, 1'b0, tm, fm, 1'b0});
    base_i = BASE | 64'h0000_0000_0000_0abc; base_we_i = 1; step();
    irq_clr_i = 1; step();
    wr_ctl(LIMIT | {59'd0, 1'b0, tm, fm, 1'b1});
  endtask

  task automatic stream(int n, int trig_at, int dens);
    for (int i = 0; i < n; i++) begin
      data_valid_i = ($urandom % 100) < dens;
      data_i = 8'($urandom);
      trig_i = (i == trig_at);
      step();
    end
    data_valid_i = 0;
  endtask

  initial begin
    void'($urandom(32'h1d5e_ed07));
    model_reset();
    #1;
    // R1
    chk("R1 mem_we", {63'd0, mem_we_o}, 64'd0);
    chk("R1 irq", {63'd0, irq_o}, 64'd0);
    chk("R1 stopped", {63'd0, stopped_o}, 64'd0);
    chk("R1 readback", ctl_rdata_o, 64'd0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);

    // R2: random control words with enable clear
    cur_req = "R2";
    for (int i = 0; i < 20; i++) wr_ctl({$urandom, $urandom} & ~64'd1);

    // R3: disabled unit discards input
    cur_req = "R3";
    wr_ctl(LIMIT | 64'h6);
    stream(50, 10, 90);
    chk("R3 no write while off", {63'd0, mem_we_o}, 64'd0);

    // R7 with a mid-run base reload (R5)
    cur_req = "R7";
    setup(2'b01, 2'b11);
    stream(100, -1, 80);
    base_i = BASE; base_we_i = 1; data_valid_i = 1; step(); data_valid_i = 0;
    cur_req = "R5";
    stream(4400, -1, 100);
    chk("R7 irq after wrap", {63'd0, irq_o}, 64'd1);

    // R11 clear and set-wins
    cur_req = "R11";
    irq_clr_i = 1; step();
    chk("R11 cleared", {63'd0, irq_o}, 64'd0);
    stream(10, -1, 50);

    // R6 fill stop, then R12 hold and re-enable
    cur_req = "R6";
    setup(2'b00, 2'b11);
    stream(4300, -1, 100);
    chk("R6 stopped", {63'd0, stopped_o}, 64'd1);
    chk("R6 irq", {63'd0, irq_o}, 64'd1);
    cur_req = "R12";
    wr_ctl(LIMIT | 64'h1);
    stream(30, -1, 100);
    chk("R12 still stopped", {63'd0, stopped_o}, 64'd1);
    wr_ctl(LIMIT | 64'h0);
    wr_ctl(LIMIT | 64'h1);
    stream(40, -1, 100);
    chk("R12 resumed", {63'd0, stopped_o}, 64'd0);

    // R8 both no-action fill encodings
    cur_req = "R8";
    setup(2'b11, 2'b11);
    stream(4300, -1, 100);
    chk("R8 circ no irq", {63'd0, irq_o}, 64'd0);
    setup(2'b10, 2'b10);
    stream(4300, 200, 100);
    chk("R8 reserved no irq", {63'd0, irq_o}, 64'd0);

    // R9 stop on trigger with and without a staged byte
    cur_req = "R9";
    setup(2'b11, 2'b00);
    stream(300, 150, 100);
    chk("R9 stopped", {63'd0, stopped_o}, 64'd1);
    setup(2'b11, 2'b00);
    stream(300, 120, 0);
    chk("R9 irq", {63'd0, irq_o}, 64'd1);

    // R10 irq on trigger; ignored encodings
    cur_req = "R10";
    setup(2'b11, 2'b01);
    stream(200, 80, 60);
    chk("R10 irq", {63'd0, irq_o}, 64'd1);
    setup(2'b11, 2'b11);
    stream(200, 80, 60);
    chk("R10 ignored", {63'd0, irq_o}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule